// File: doc/BRIEF.md
# Tri-Mode Buck-Boost Mode Selector

This block chooses how a four-switch buck-boost power stage operates: as a pure buck, as a full buck-boost, or as a pure boost. It watches the digital buck and boost duty commands, given in percent, that the loop controller produces. A mode changes only when its entry condition has held on several consecutive switching ticks. The idle leg of the bridge is forced into a fixed state through two force outputs.

Entry and exit thresholds differ at each boundary. This hysteresis keeps the stage from chattering when a duty command sits near a boundary. When the mode changes, the block emits a single-cycle feedforward strobe that carries preset duties for the new mode, so that the duty generator can jump straight to a sensible operating point and does not have to wait for the integrator to slew. The block starts in buck mode after reset.

Top module: `tri_mode_sel`

## Requirements
- R1: After reset, mode is buck (code 0), the feedforward strobe is 0 and both feedforward duty outputs are 0.
- R2: In buck mode boost_hi_force=1 and buck_hi_force=0. In boost mode buck_hi_force=1 and boost_hi_force=0. In buck-boost mode both are 0.
- R3: From buck, the mode moves to buck-boost (code 1) once buck_duty >= 90 on 4 consecutive ticks. A buck duty of 89 never moves it.
- R4: From buck-boost, the mode moves to boost (code 2) once boost_duty >= 30 on 4 consecutive ticks. This condition takes precedence over the exit toward buck.
- R5: From buck-boost, the mode moves to buck once buck_duty < 85 with boost_duty < 30 on 4 consecutive ticks.
- R6: From boost, the mode moves to buck-boost once boost_duty < 25 on 4 consecutive ticks.
- R7: Hysteresis. In buck-boost a buck duty of 85 to 89 with a boost duty below 30 keeps the mode. In boost a boost duty of 25 to 29 keeps the mode.
- R8: A tick on which the condition fails restarts the consecutive count. Clock cycles without a tick neither advance nor restart the count, and the mode changes only on clock edges where tick=1.
- R9: A mode change raises ff_strobe for exactly the one clock cycle that follows the changing edge. While the strobe is high, the presets (buck, boost) are (90,10) entering buck-boost from buck, (100,30) entering boost, (100,25) entering buck-boost from boost, and (85,0) entering buck. Both feedforward duties are 0 whenever ff_strobe is 0.
- R10: The mode code is never 3, and boost is never entered directly from buck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per switching period |
| buck_duty | input | 8 | Commanded buck duty, percent |
| boost_duty | input | 8 | Commanded boost duty, percent |
| mode | output | 2 | 0 buck, 1 buck-boost, 2 boost |
| buck_hi_force | output | 1 | Hold the buck-side high switch on |
| boost_hi_force | output | 1 | Hold the boost-side high switch on |
| ff_strobe | output | 1 | Feedforward strobe on a mode change |
| ff_buck | output | 8 | Preset buck duty, valid with strobe |
| ff_boost | output | 8 | Preset boost duty, valid with strobe |

## Verification
The assertions check the following on every cycle:
- A strobe appears exactly when the mode changes, lasts one cycle, and never follows a tick-less edge.
- The force outputs never both assert.
- The mode code stays legal and never jumps from buck straight to boost.
- The feedforward duties are zero outside a strobe.

Only the bench scenarios can show the threshold values, the hysteresis bands, the 4-tick qualification with its restart, the precedence of the boost entry, and the preset values. The bench checks these against a behavioural model that is compared on every clock.

// File: rtl/tri_mode_sel.sv
module tri_mode_sel #(
  parameter int W            = 8,
  parameter int BB_ENTER     = 90,
  parameter int BB_EXIT      = 85,
  parameter int BOOST_ENTER  = 30,
  parameter int BOOST_EXIT   = 25,
  parameter int BB_PRESET    = 10,
  parameter int FULL         = 100,
  parameter int QUAL         = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] buck_duty,
  input  logic [W-1:0] boost_duty,
  output logic [1:0]   mode,
  output logic         buck_hi_force,
  output logic         boost_hi_force,
  output logic         ff_strobe,
  output logic [W-1:0] ff_buck,
  output logic [W-1:0] ff_boost
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [1:0] M_BUCK = 2'd0, M_BB = 2'd1, M_BOOST = 2'd2;
  localparam logic [W-1:0] T_BB_IN  = W'(BB_ENTER);
  localparam logic [W-1:0] T_BB_OUT = W'(BB_EXIT);
  localparam logic [W-1:0] T_BO_IN  = W'(BOOST_ENTER);
  localparam logic [W-1:0] T_BO_OUT = W'(BOOST_EXIT);
  localparam logic [CW-1:0] Q_C     = CW'(QUAL);

  logic [1:0]    tgt, pend;
  logic          want;
  logic [CW-1:0] cnt, cnt_nx;
  logic [W-1:0]  pre_buck, pre_boost;

  always_comb begin
    want = 1'b0;
    tgt  = mode;
    case (mode)
      M_BUCK:  if (buck_duty >= T_BB_IN) begin want = 1'b1; tgt = M_BB; end
      M_BB:    if (boost_duty >= T_BO_IN) begin want = 1'b1; tgt = M_BOOST; end
               else if (buck_duty < T_BB_OUT) begin want = 1'b1; tgt = M_BUCK; end
      M_BOOST: if (boost_duty < T_BO_OUT) begin want = 1'b1; tgt = M_BB; end
      default: begin want = 1'b1; tgt = M_BUCK; end
    endcase
  end

  always_comb begin
    case (tgt)
      M_BB:    begin
                 pre_buck  = (mode == M_BOOST) ? W'(FULL) : T_BB_IN;
                 pre_boost = (mode == M_BOOST) ? T_BO_OUT : W'(BB_PRESET);
               end
      M_BOOST: begin pre_buck = W'(FULL); pre_boost = T_BO_IN; end
      default: begin pre_buck = T_BB_OUT; pre_boost = '0; end
    endcase
  end

  assign cnt_nx = (cnt != '0 && pend == tgt) ? cnt + CW'(1) : CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_BUCK;
      pend      <= M_BUCK;
      cnt       <= '0;
      ff_strobe <= 1'b0;
      ff_buck   <= '0;
      ff_boost  <= '0;
    end else begin
      ff_strobe <= 1'b0;
      ff_buck   <= '0;
      ff_boost  <= '0;
      if (tick) begin
        if (!want) begin
          cnt <= '0;
        end else if (cnt_nx == Q_C) begin
          mode      <= tgt;
          cnt       <= '0;
          ff_strobe <= 1'b1;
          ff_buck   <= pre_buck;
          ff_boost  <= pre_boost;
        end else begin
          cnt  <= cnt_nx;
          pend <= tgt;
        end
      end
    end
  end

  assign boost_hi_force = (mode == M_BUCK);
  assign buck_hi_force  = (mode == M_BOOST);
endmodule

// File: rtl/tri_mode_sel_chk.sv
module tri_mode_sel_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [1:0]   mode,
  input logic         buck_hi_force,
  input logic         boost_hi_force,
  input logic         ff_strobe,
  input logic [W-1:0] ff_buck,
  input logic [W-1:0] ff_boost
);
  assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ff_strobe);
  assert_change_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ff_strobe |-> (mode != $past(mode)));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ff_strobe |=> !ff_strobe);
  assert_ff_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_strobe |-> (ff_buck == '0 && ff_boost == '0));
  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode));
  assert_force_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buck_hi_force, boost_hi_force}));
  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  assert_no_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> ($past(mode) != 2'd0));
endmodule

bind tri_mode_sel tri_mode_sel_chk #(.W(W)) chk_i (.*);

// File: tb/tri_mode_sel_tb.sv
`timescale 1ns/1ps
module tri_mode_sel_tb_top;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] buck_duty = 0, boost_duty = 0;
  logic [1:0] mode;
  logic buck_hi_force, boost_hi_force, ff_strobe;
  logic [7:0] ff_buck, ff_boost;
  int total = 0, bad = 0;
  string req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  tri_mode_sel dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .buck_duty(buck_duty),
    .boost_duty(boost_duty), .mode(mode), .buck_hi_force(buck_hi_force),
    .boost_hi_force(boost_hi_force), .ff_strobe(ff_strobe), .ff_buck(ff_buck),
    .ff_boost(ff_boost));

  int m_mode, m_cnt, m_pend, m_str, m_fb, m_fo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_pend = 0; m_str = 0; m_fb = 0; m_fo = 0;
    end else begin
      int tg;
      m_str = 0; m_fb = 0; m_fo = 0;
      if (tick) begin
        tg = m_mode;
        if (m_mode == 0 && buck_duty >= 90) tg = 1;
        else if (m_mode == 1 && boost_duty >= 30) tg = 2;
        else if (m_mode == 1 && buck_duty < 85) tg = 0;
        else if (m_mode == 2 && boost_duty < 25) tg = 1;
        if (tg == m_mode) m_cnt = 0;
        else begin
          m_cnt = (m_cnt > 0 && m_pend == tg) ? m_cnt + 1 : 1;
          m_pend = tg;
          if (m_cnt == 4) begin
            if (tg == 1 && m_mode == 0) begin m_fb = 90; m_fo = 10; end
            else if (tg == 1) begin m_fb = 100; m_fo = 25; end
            else if (tg == 2) begin m_fb = 100; m_fo = 30; end
            else begin m_fb = 85; m_fo = 0; end
            m_mode = tg; m_cnt = 0; m_str = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (mode != m_mode[1:0] || ff_strobe != m_str[0] || ff_buck != m_fb[7:0] ||
        ff_boost != m_fo[7:0] || boost_hi_force != (m_mode == 0) ||
        buck_hi_force != (m_mode == 2)) begin
      bad++;
      $display("FAIL %s model: act mode=%0d str=%0d ff=%0d/%0d frc=%0d%0d exp mode=%0d str=%0d ff=%0d/%0d",
        req, mode, ff_strobe, ff_buck, ff_boost, buck_hi_force, boost_hi_force,
        m_mode, m_str, m_fb, m_fo);
    end
  end

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic tk(int gap);
    tick = 1; @(negedge clk); tick = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic tk1();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) tk(gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    chk("R1 mode", mode, 0); chk("R1 strobe", ff_strobe, 0);
    chk("R1 ff", ff_buck + ff_boost, 0);
    rst_n = 1; @(negedge clk);
    req = "R2"; chk("R2 buck force", {buck_hi_force, boost_hi_force}, 1);
    req = "R3"; buck_duty = 89; ticks(10, 1); chk("R3 89 stays", mode, 0);
    req = "R8"; buck_duty = 90; ticks(3, 2); buck_duty = 50; ticks(1, 0);
    buck_duty = 90; ticks(3, 2); chk("R8 restart", mode, 0);
    repeat (20) @(negedge clk); chk("R8 no tick", mode, 0);
    req = "R3"; tk1(); chk("R3 enter bb", mode, 1);
    req = "R9"; chk("R9 str", ff_strobe, 1); chk("R9 buck", ff_buck, 90); chk("R9 boost", ff_boost, 10);
    @(negedge clk); chk("R9 one cycle", ff_strobe, 0); chk("R9 zero", ff_buck, 0);
    req = "R7"; buck_duty = 85; boost_duty = 29; ticks(8, 0); chk("R7 bb hold", mode, 1);
    req = "R2"; chk("R2 bb force", {buck_hi_force, boost_hi_force}, 0);
    req = "R4"; buck_duty = 50; boost_duty = 30; ticks(3, 0); chk("R4 three", mode, 1);
    tk1(); chk("R4 boost first", mode, 2); chk("R9 boost ff", ff_buck * 1000 + ff_boost, 100030);
    req = "R2"; chk("R2 boost force", {buck_hi_force, boost_hi_force}, 2);
    req = "R7"; boost_duty = 25; ticks(8, 1); chk("R7 boost hold", mode, 2);
    req = "R6"; boost_duty = 24; ticks(3, 1); tk1(); chk("R6 to bb", mode, 1);
    chk("R9 bb from boost", ff_buck * 1000 + ff_boost, 100025);
    req = "R5"; boost_duty = 10; buck_duty = 84; ticks(3, 0); tk1(); chk("R5 to buck", mode, 0);
    chk("R9 buck ff", ff_buck * 1000 + ff_boost, 85000);
    req = "R10"; buck_duty = 100; boost_duty = 90; ticks(6, 0); chk("R10 no skip", mode, 1);
    ticks(4, 0); chk("R10 then boost", mode, 2);
    req = "R1"; rst_n = 0; @(negedge clk); chk("R1 async", mode, 0); rst_n = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule